// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves words between a fixed peripheral FIFO address and two memory buffers used in alternation. Software programs a start address and a transfer count for each buffer, enables one or both, and sets a go bit. The channel then issues one request at a time on a simple request/acknowledge master port. Each acknowledged transfer lowers the active buffer's count and advances its address by the device width. When a buffer's count reaches zero, the channel retires that buffer and switches to the other one. While the channel runs from one buffer, software refills the buffer that has just finished.

The control and status word has two write addresses. One address sets every bit written as one and the other clears every bit written as one, so software never needs a read-modify-write. A halted flag confirms that the channel has stopped after software clears go. An interrupt is raised while any done flag is set and interrupts are enabled. The residue output gives the bytes still owed by the active buffer.

Top module: `pingpong_dma_chan`

## Requirements
- R1: A write to offset 0x00 ORs the written ones into the mode word, and a write to offset 0x04 clears every bit written as one. A read at 0x00 returns the mode word. Bits 14 and 31:24 always read 0. Bit 6 (halted) ignores software writes. Bit map of the mode word:
  - bit 0 / bit 1: buffer0 enable / buffer0 done.
  - bit 2 / bit 3: buffer1 enable / buffer1 done.
  - bit 4: active buffer (1 = buffer1).
  - bit 5: go. Bit 6: halted. Bit 7: interrupt enable.
  - bits 10:9: width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 treated as 8-bit).
  - bit 12: direction. Bits 23:20: high device address.
  - bits 8, 11, 13, 15 and 19:16: stored and read back only.
- R2: After reset the mode word reads 0x0000_0040 (only halted set), irq is 0 and mst_req is 0.
- R3: Offset 0x08 holds the 32-bit peripheral address. Offsets 0x0C and 0x14 hold the start addresses of buffer0 and buffer1. Offsets 0x10 and 0x18 hold the count registers of buffer0 and buffer1: count in bits 15:0, high address bits in bits 19:16, bits 31:20 read 0. All read back. The start and count registers show the live values while transfers run.
- R4: When go is set, the active buffer is enabled and its count is nonzero, the channel raises mst_req with:
  - mst_mem_addr = {buffer high bits, buffer start};
  - mst_dev_addr = {mode bits 23:20, peripheral address};
  - mst_dir = mode bit 12 and mst_width = mode bits 10:9.
  These values stay stable until mst_ack.
- R5: Each acknowledged transfer lowers that buffer's count by one and adds 1, 2 or 4 to its start address for width codes 0, 1 and 2 (1 for code 3). The start address wraps at 32 bits.
- R6: When the active buffer is enabled with a zero count while go is set, the channel clears that buffer's enable, sets its done bit and toggles the active bit. This includes a buffer enabled with count 0, which finishes without any transfer.
- R7: After a switch, the channel continues from the other buffer if that buffer is enabled. If it is not enabled, the channel stalls: no request, halted stays 0.
- R8: When go is cleared, a pending request stays up until it is acknowledged, and halted is 0 until then. The cycle after the request ends, halted reads 1. Setting go clears halted, and halted and mst_req are never high together.
- R9: irq = bit 7 AND (bit 1 OR bit 3). Both done bits can be set together, each is cleared on its own, and irq stays high until both are cleared.
- R10: residue_bytes equals the active buffer's count shifted left by 1 for width code 1, by 2 for code 2, and not shifted otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mst_req | output | 1 | Transfer request, held until acknowledged |
| mst_ack | input | 1 | Transfer acknowledge, one cycle |
| mst_mem_addr | output | 36 | Memory byte address of the transfer |
| mst_dev_addr | output | 36 | Peripheral FIFO address of the transfer |
| mst_dir | output | 1 | Direction bit captured at request |
| mst_width | output | 2 | Width code captured at request |
| irq | output | 1 | Buffer-done interrupt |
| residue_bytes | output | 18 | Bytes left in the active buffer |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Hand-over between buffers.** A channel that forgets to toggle the active bit would keep reading the drained buffer. One that fails to clear the enable bit would finish the same buffer again and again.
- **A buffer enabled with a zero count.** This must finish without issuing a request. A design that decrements first would wrap to 65535 transfers.
- **Go cleared while a request is pending.** A design that raises halted early, or drops the request before the acknowledge, shows it at the ports.
- **Width codes 0 to 3 under random acknowledge delays.** These check both the address stride and the byte residue, so a wrong shift gives a wrong address or residue.
- **Clearing one done bit at a time.** This shows whether irq follows the other buffer's flag.

// File: rtl/ppdma_pkg.sv
// Package: shared offsets, bit positions and helpers for the ping-pong DMA channel.
// Assumes a 32-bit register bus and byte offsets on 5 address bits.
package ppdma_pkg;

    localparam int REG_W = 32;
    localparam int NBUF  = 2;

    localparam logic [4:0] OFS_MODE_SET = 5'h00;
    localparam logic [4:0] OFS_MODE_CLR = 5'h04;
    localparam logic [4:0] OFS_PERIPH   = 5'h08;
    localparam logic [4:0] OFS_B0_START = 5'h0C;
    localparam logic [4:0] OFS_B0_CNT   = 5'h10;
    localparam logic [4:0] OFS_B1_START = 5'h14;
    localparam logic [4:0] OFS_B1_CNT   = 5'h18;
    localparam int         OFS_BUF_STEP = 8;

    localparam int BIT_EN0 = 0;
    localparam int BIT_DN0 = 1;
    localparam int BIT_EN1 = 2;
    localparam int BIT_DN1 = 3;
    localparam int BIT_ACT = 4;
    localparam int BIT_GO  = 5;
    localparam int BIT_HLT = 6;
    localparam int BIT_IE  = 7;
    localparam int WID_LO  = 9;
    localparam int BIT_DIR = 12;
    localparam int DHI_LO  = 20;

    // Bits software may write; halted is hardware-owned, 14 and 31:24 are reserved.
    localparam logic [REG_W-1:0] MODE_SW_MASK = 32'h00FF_BFBF;
    localparam logic [REG_W-1:0] MODE_RESET   = 32'h0000_0040;

    // Shift from device units to bytes for a width code.
    function automatic logic [1:0] width_shift(input logic [1:0] code);
        case (code)
            2'd1:    width_shift = 2'd1;
            2'd2:    width_shift = 2'd2;
            default: width_shift = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ppdma_mode_reg.sv
// Module: holds the mode/status word. Applies hardware completion events first,
// then software set and clear writes, and takes halted from the transfer engine.
// Assumes set_we and clr_we are never high in the same cycle.
module ppdma_mode_reg
    import ppdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             cpl,
    input  logic             cpl_buf,
    input  logic             halt_nxt,
    output logic [REG_W-1:0] mode_q
);

    logic [REG_W-1:0] mode_d;

    // Next-state merge: hardware retire, software set/clear, halted status.
    always_comb begin
        mode_d = mode_q;
        if (cpl) begin
            mode_d[cpl_buf ? BIT_EN1 : BIT_EN0] = 1'b0;
            mode_d[cpl_buf ? BIT_DN1 : BIT_DN0] = 1'b1;
            mode_d[BIT_ACT]                     = ~mode_q[BIT_ACT];
        end
        if (set_we) mode_d = mode_d | (wdata & MODE_SW_MASK);
        if (clr_we) mode_d = mode_d & ~(wdata & MODE_SW_MASK);
        mode_d[BIT_HLT] = halt_nxt;
        mode_d = mode_d & (MODE_SW_MASK | MODE_RESET);
    end

    // Mode word register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RESET;
        else        mode_q <= mode_d;
    end

    // R6: a retired buffer shows its done flag next cycle unless software clears it.
    a_r6_done0_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && !cpl_buf && !clr_we) |=> mode_q[BIT_DN0]);
    a_r6_done1_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && cpl_buf && !clr_we) |=> mode_q[BIT_DN1]);
    // R8: halted only rises after a cycle with go low.
    a_r8_halt_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q[BIT_HLT]) |-> !$past(mode_q[BIT_GO]));

endmodule

// File: rtl/ppdma_buf_slot.sv
// Module: one buffer's start address, transfer count and high address bits.
// A software write wins over a same-cycle hardware step.
// Assumes step is only pulsed while the count is nonzero.
module ppdma_buf_slot #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              cnt_we,
    input  logic [ADDR_W-1:0] start_wd,
    input  logic [CNT_W-1:0]  cnt_wd,
    input  logic [HI_W-1:0]   hi_wd,
    input  logic              step,
    input  logic [2:0]        step_bytes,
    output logic [ADDR_W-1:0] start_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [HI_W-1:0]   hi_q
);

    // Address pointer: load from software or advance by the transfer size.
    always_ff @(posedge clk) begin
        if (!rst_n)        start_q <= '0;
        else if (start_we) start_q <= start_wd;
        else if (step)     start_q <= start_q + ADDR_W'(step_bytes);
    end

    // Count and high bits: load from software or count down per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wd;
            hi_q  <= hi_wd;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R5: the engine never steps a buffer whose count is already zero.
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q != '0));

endmodule

// File: rtl/ppdma_xfer.sv
// Module: transfer engine. Issues one request at a time from the active buffer,
// retires a buffer when its count is zero, and computes the next halted value.
// Assumes mst_ack is only high while mst_req is high.
module ppdma_xfer
    import ppdma_pkg::*;
#(
    parameter int MA_W = 36
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic                      act,
    input  logic [NBUF-1:0]           en,
    input  logic [NBUF-1:0]           cnt_zero,
    input  logic [NBUF-1:0][MA_W-1:0] buf_addr,
    input  logic [MA_W-1:0]           dev_addr,
    input  logic                      dir,
    input  logic [1:0]                width,
    input  logic                      mst_ack,
    output logic                      mst_req,
    output logic [MA_W-1:0]           mst_mem_addr,
    output logic [MA_W-1:0]           mst_dev_addr,
    output logic                      mst_dir,
    output logic [1:0]                mst_width,
    output logic [NBUF-1:0]           step,
    output logic                      cpl,
    output logic                      cpl_buf,
    output logic                      halt_nxt
);

    logic req_q;
    logic cur_q;
    logic issue;
    logic xfer_done;

    // Decide this cycle's action: issue, retire or idle.
    always_comb begin
        issue     = go && !req_q && en[act] && !cnt_zero[act];
        cpl       = go && !req_q && en[act] &&  cnt_zero[act];
        cpl_buf   = act;
        xfer_done = req_q && mst_ack;
        halt_nxt  = !go && !(req_q && !mst_ack);
        step      = '0;
        step[cur_q] = xfer_done;
    end

    // Request register with captured addresses and attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q        <= 1'b0;
            cur_q        <= 1'b0;
            mst_mem_addr <= '0;
            mst_dev_addr <= '0;
            mst_dir      <= 1'b0;
            mst_width    <= 2'd0;
        end else if (issue) begin
            req_q        <= 1'b1;
            cur_q        <= act;
            mst_mem_addr <= buf_addr[act];
            mst_dev_addr <= dev_addr;
            mst_dir      <= dir;
            mst_width    <= width;
        end else if (xfer_done) begin
            req_q <= 1'b0;
        end
    end

    assign mst_req = req_q;

    // R4: a pending request holds its address until acknowledged.
    a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !mst_ack) |=> (req_q && $stable(mst_mem_addr) && $stable(mst_dev_addr)));
    // R4: a new request starts only while go is set.
    a_r4_req_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(go));

endmodule

// File: rtl/pingpong_dma_chan.sv
// Module: top of the ping-pong DMA channel. Decodes register writes, muxes
// readback, holds the peripheral address and wires the buffer slots, mode word
// and transfer engine. Assumes one register write per cycle and reads that
// are combinational on reg_addr.
module pingpong_dma_chan
    import ppdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int HI_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [4:0]               reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     mst_req,
    input  logic                     mst_ack,
    output logic [ADDR_W+HI_W-1:0]   mst_mem_addr,
    output logic [ADDR_W+HI_W-1:0]   mst_dev_addr,
    output logic                     mst_dir,
    output logic [1:0]               mst_width,
    output logic                     irq,
    output logic [CNT_W+1:0]         residue_bytes
);

    localparam int MA_W   = ADDR_W + HI_W;
    localparam int HI_LSB = CNT_W;

    logic [REG_W-1:0]            mode_q;
    logic [ADDR_W-1:0]           periph_q;
    logic [NBUF-1:0][ADDR_W-1:0] start_q;
    logic [NBUF-1:0][CNT_W-1:0]  cnt_q;
    logic [NBUF-1:0][HI_W-1:0]   hi_q;
    logic [NBUF-1:0][MA_W-1:0]   buf_addr;
    logic [NBUF-1:0]             cnt_zero;
    logic [NBUF-1:0]             step;
    logic [NBUF-1:0]             en;
    logic                        cpl;
    logic                        cpl_buf;
    logic                        halt_nxt;
    logic [2:0]                  step_bytes;
    logic                        act;

    assign act        = mode_q[BIT_ACT];
    assign en         = {mode_q[BIT_EN1], mode_q[BIT_EN0]};
    assign step_bytes = 3'd1 << width_shift(mst_width);

    // Peripheral FIFO address register.
    always_ff @(posedge clk) begin
        if (!rst_n)                              periph_q <= '0;
        else if (reg_we && reg_addr == OFS_PERIPH) periph_q <= reg_wdata[ADDR_W-1:0];
    end

    ppdma_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (reg_we && reg_addr == OFS_MODE_SET),
        .clr_we   (reg_we && reg_addr == OFS_MODE_CLR),
        .wdata    (reg_wdata),
        .cpl      (cpl),
        .cpl_buf  (cpl_buf),
        .halt_nxt (halt_nxt),
        .mode_q   (mode_q)
    );

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        localparam logic [4:0] START_OFS = 5'(int'(OFS_B0_START) + OFS_BUF_STEP * b);
        localparam logic [4:0] CNT_OFS   = 5'(int'(OFS_B0_CNT) + OFS_BUF_STEP * b);

        ppdma_buf_slot #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .HI_W   (HI_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_we   (reg_we && reg_addr == START_OFS),
            .cnt_we     (reg_we && reg_addr == CNT_OFS),
            .start_wd   (reg_wdata[ADDR_W-1:0]),
            .cnt_wd     (reg_wdata[CNT_W-1:0]),
            .hi_wd      (reg_wdata[HI_LSB +: HI_W]),
            .step       (step[b]),
            .step_bytes (step_bytes),
            .start_q    (start_q[b]),
            .cnt_q      (cnt_q[b]),
            .hi_q       (hi_q[b])
        );

        assign buf_addr[b] = {hi_q[b], start_q[b]};
        assign cnt_zero[b] = (cnt_q[b] == '0);
    end

    ppdma_xfer #(
        .MA_W (MA_W)
    ) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (mode_q[BIT_GO]),
        .act          (act),
        .en           (en),
        .cnt_zero     (cnt_zero),
        .buf_addr     (buf_addr),
        .dev_addr     ({mode_q[DHI_LO +: HI_W], periph_q}),
        .dir          (mode_q[BIT_DIR]),
        .width        (mode_q[WID_LO +: 2]),
        .mst_ack      (mst_ack),
        .mst_req      (mst_req),
        .mst_mem_addr (mst_mem_addr),
        .mst_dev_addr (mst_dev_addr),
        .mst_dir      (mst_dir),
        .mst_width    (mst_width),
        .step         (step),
        .cpl          (cpl),
        .cpl_buf      (cpl_buf),
        .halt_nxt     (halt_nxt)
    );

    // Register readback mux.
    always_comb begin
        case (reg_addr)
            OFS_MODE_SET: reg_rdata = mode_q;
            OFS_PERIPH:   reg_rdata = REG_W'(periph_q);
            OFS_B0_START: reg_rdata = REG_W'(start_q[0]);
            OFS_B0_CNT:   reg_rdata = REG_W'({hi_q[0], cnt_q[0]});
            OFS_B1_START: reg_rdata = REG_W'(start_q[1]);
            OFS_B1_CNT:   reg_rdata = REG_W'({hi_q[1], cnt_q[1]});
            default:      reg_rdata = '0;
        endcase
    end

    // Interrupt and byte residue of the active buffer.
    always_comb begin
        irq           = mode_q[BIT_IE] && (mode_q[BIT_DN0] || mode_q[BIT_DN1]);
        residue_bytes = (CNT_W+2)'(cnt_q[act]) << width_shift(mode_q[WID_LO +: 2]);
    end

    // R8: a halted channel has no request outstanding.
    a_r8_halt_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[BIT_HLT] |-> !mst_req);

endmodule

// File: tb/tb_pingpong_dma_chan.sv
module tb_pingpong_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = 5'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mst_req;
    logic        mst_ack = 1'b0;
    logic [35:0] mst_mem_addr;
    logic [35:0] mst_dev_addr;
    logic        mst_dir;
    logic [1:0]  mst_width;
    logic        irq;
    logic [17:0] residue_bytes;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    pingpong_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_req(mst_req),
        .mst_ack(mst_ack), .mst_mem_addr(mst_mem_addr), .mst_dev_addr(mst_dev_addr),
        .mst_dir(mst_dir), .mst_width(mst_width), .irq(irq),
        .residue_bytes(residue_bytes)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int stride(input int w);
        return (w == 1) ? 2 : (w == 2) ? 4 : 1;
    endfunction

    function automatic int shf(input int w);
        return (w == 1) ? 1 : (w == 2) ? 2 : 0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait for a request, check it, then acknowledge after a delay.
    task automatic serve(input string tag, input logic [35:0] mem, input logic [35:0] dev,
                         input logic dir, input int dly);
        int waited = 0;
        while (!mst_req && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        check({tag, " req"}, 64'(mst_req), 64'd1);
        if (mst_req) begin
            check({tag, " mem"}, 64'(mst_mem_addr), 64'(mem));
            check({tag, " dev"}, 64'(mst_dev_addr), 64'(dev));
            check({tag, " dir"}, 64'(mst_dir), 64'(dir));
            repeat (dly) @(negedge clk);
            mst_ack = 1'b1;
            @(negedge clk);
            mst_ack = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] v;
        int seen;
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        rd(5'h00, v); check("R2 mode", 64'(v), 64'h40);
        check("R2 irq", 64'(irq), 0);
        check("R2 req", 64'(mst_req), 0);

        // R1: set/clear, reserved bits, halted not writable
        wr(5'h00, 32'hFFFF_FFC0);
        rd(5'h00, v); check("R1 set", 64'(v), 64'h00FF_BFC0);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h00, v); check("R1 clr halted kept", 64'(v), 64'h40);
        wr(5'h00, 32'h0000_2900);
        wr(5'h04, 32'h0000_0800);
        rd(5'h00, v); check("R1 partial clr", 64'(v), 64'h2140);
        wr(5'h04, 32'hFFFF_FFFF);

        // R3: register readback
        wr(5'h08, 32'h1000_0000);
        wr(5'h0C, 32'h0000_0100);
        wr(5'h10, 32'hFFF2_0003);
        wr(5'h14, 32'h0000_0800);
        wr(5'h18, 32'h0000_0002);
        rd(5'h08, v); check("R3 periph", 64'(v), 64'h1000_0000);
        rd(5'h10, v); check("R3 cnt0 mask", 64'(v), 64'h0002_0003);
        rd(5'h14, v); check("R3 start1", 64'(v), 64'h800);

        // R10: residue of buffer0 at 16-bit width
        wr(5'h00, 32'h0050_1280);
        check("R10 residue16", 64'(residue_bytes), 64'd6);

        // R4 R5 R6 R7: ping-pong run
        wr(5'h00, 32'h0000_0025);
        for (int i = 0; i < 3; i++)
            serve("R4 buf0", {4'h2, 32'h100 + 32'(i * 2)}, 36'h5_1000_0000, 1'b1, i);
        rd(5'h10, v); check("R5 cnt0 zero", 64'(v), 64'h0002_0000);
        rd(5'h0C, v); check("R5 start0 adv", 64'(v), 64'h106);
        for (int i = 0; i < 2; i++)
            serve("R7 buf1", {4'h0, 32'h800 + 32'(i * 2)}, 36'h5_1000_0000, 1'b1, 1);
        idle(5);
        rd(5'h00, v); check("R6 retire both", 64'(v), 64'h0050_12AA);
        check("R7 stall req", 64'(mst_req), 0);
        check("R9 irq both", 64'(irq), 1);

        // R9: independent done clears
        wr(5'h04, 32'h2);
        rd(5'h00, v); check("R9 dn0 clr", 64'(v & 32'hA), 64'h8);
        check("R9 irq kept", 64'(irq), 1);
        wr(5'h04, 32'h8);
        check("R9 irq off", 64'(irq), 0);

        // R8: halt with a pending request
        wr(5'h10, 32'h2);
        wr(5'h00, 32'h1);
        wr(5'h00, 32'h20);
        seen = 0;
        while (!mst_req && seen < 20) begin @(negedge clk); seen++; end
        rd(5'h00, v); check("R8 go clears halted", 64'(v[6]), 0);
        wr(5'h04, 32'h20);
        idle(3);
        check("R8 req held", 64'(mst_req), 1);
        rd(5'h00, v); check("R8 not halted yet", 64'(v[6]), 0);
        check("R8 mem", 64'(mst_mem_addr), 64'h106);
        mst_ack = 1'b1; @(negedge clk); mst_ack = 1'b0;
        check("R8 req off", 64'(mst_req), 0);
        rd(5'h00, v); check("R8 halted", 64'(v[6]), 1);
        rd(5'h10, v); check("R5 cnt0 after halt", 64'(v), 64'h1);

        // R6: zero-count buffer retires without a transfer
        wr(5'h10, 32'h0);
        wr(5'h00, 32'h20);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (mst_req) seen++;
            @(negedge clk);
        end
        check("R6 zero no req", 64'(seen), 0);
        rd(5'h00, v); check("R6 zero retire", 64'(v & 32'h7F), 64'h32);
        wr(5'h04, 32'h20);
        idle(2);
        rd(5'h00, v); check("R8 halted again", 64'(v[6]), 1);

        // Random rounds: R4 R5 R6 R7 R10
        for (int r = 0; r < 20; r++) begin
            int w = int'($urandom % 4);
            int c0 = 1 + int'($urandom % 5);
            int c1 = 1 + int'($urandom % 5);
            logic [31:0] s0 = $urandom;
            logic [31:0] s1 = $urandom;
            logic [3:0] h0 = 4'($urandom);
            logic [3:0] h1 = 4'($urandom);
            logic [3:0] dh = 4'($urandom);
            logic dir = 1'($urandom);
            logic [31:0] pa = $urandom;
            logic [31:0] base;
            if (r == 0) s0 = 32'hFFFF_FFFE;
            base = (32'(w) << 9) | (32'(dir) << 12) | (32'(dh) << 20) | 32'h80;
            wr(5'h04, 32'hFFFF_FFFF);
            wr(5'h08, pa);
            wr(5'h0C, s0);
            wr(5'h14, s1);
            wr(5'h10, (32'(h0) << 16) | 32'(c0));
            wr(5'h18, (32'(h1) << 16) | 32'(c1));
            wr(5'h00, base);
            check("R10 residue", 64'(residue_bytes), 64'(c0 << shf(w)));
            wr(5'h00, 32'h25);
            for (int i = 0; i < c0; i++)
                serve("R5 rnd buf0", {h0, s0 + 32'(i * stride(w))}, {dh, pa}, dir,
                      int'($urandom % 4));
            for (int i = 0; i < c1; i++)
                serve("R7 rnd buf1", {h1, s1 + 32'(i * stride(w))}, {dh, pa}, dir,
                      int'($urandom % 4));
            idle(5);
            rd(5'h00, v); check("R6 rnd mode", 64'(v), 64'(base | 32'h2A));
            check("R9 rnd irq", 64'(irq), 1);
            wr(5'h04, 32'h20);
            idle(2);
            rd(5'h00, v); check("R8 rnd halted", 64'(v[6]), 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule